// File: doc/BRIEF.md
# Prescaled Countdown Timer

This block is a 32-bit down-counter that advances on divided ticks. A base tick enters a power-of-two prescaler, and every divided tick it produces steps the counter. Three write ports load the timer's settings: the starting count, a 4-bit divide setting and a control word. The control word selects one-shot or periodic operation, masks expiry, and supplies the 8-bit vector that an expiry carries.

The current count is always readable. Each expiry produces a one-cycle request pulse that carries the vector and a trigger-mode flag, which is always edge. The parent block places the request into its own pending-interrupt state. In one-shot mode the counter drains to zero, raises one request on the following divided tick and then stays idle. In periodic mode the counter reloads from the starting value after reaching zero, so each cycle through the count lasts one divided tick longer than the starting value.

Top module: `tick_countdown_timer`

## Requirements
- R1: The divide setting `div_cfg` forms a 3-bit code v = {div_cfg[3], div_cfg[1:0]}. The prescale shift is (v + 1) mod 8, and one divided tick occurs every 2^shift base ticks. Code 7 divides by 1. Bit 2 of `div_cfg` has no effect.
- R2: A write of the starting count or of the divide setting clears the prescaler. The first divided tick after such a write comes a full 2^shift base ticks later.
- R3: A write of the starting count loads `cur_count` with the written value at the next clock edge. If a divided tick falls in the same cycle as the write, the tick is discarded.
- R4: In one-shot mode (`ctrl_data[17]` = 0), `cur_count` equals the starting count minus the divided ticks elapsed since the load, and it stops at 0.
- R5: In one-shot mode, exactly one request is raised, on the divided tick that brings the elapsed count to start + 1. No request follows it. A starting count of 0 raises no request.
- R6: In periodic mode (`ctrl_data[17]` = 1), `cur_count` equals start − (elapsed mod (start + 1)), and a request is raised every start + 1 divided ticks.
- R7: While the mask bit (`ctrl_data[16]` = 1) is set, no request is raised, but counting continues unchanged.
- R8: A control-word write changes mode and mask for every later expiry without disturbing the count. Clearing the mask before expiry lets that expiry raise its request. Switching from periodic to one-shot before the first reload still yields the one-shot request.
- R9: A request is `irq_valid` high for one cycle, starting in the cycle after the edge that processed the expiring divided tick. In that cycle `irq_vector` equals `ctrl_data[7:0]` of the control word in force, and `irq_level` is 0 (edge).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Base tick enable, one per counting step before division |
| init_we | input | 1 | Write strobe for the starting count |
| init_data | input | 32 | Starting count |
| div_we | input | 1 | Write strobe for the divide setting |
| div_cfg | input | 4 | Divide setting (bits 3, 1, 0 used) |
| ctrl_we | input | 1 | Write strobe for the control word |
| ctrl_data | input | 32 | Control word: [17] periodic, [16] mask, [7:0] vector |
| cur_count | output | 32 | Current count |
| irq_valid | output | 1 | One-cycle expiry request |
| irq_vector | output | 8 | Vector carried by the request |
| irq_level | output | 1 | Trigger mode of the request, 0 = edge |

## Verification
A starting-count write can land in the same cycle as a divided tick. In that case the load must win and the tick must leave no trace in either the count or the prescaler phase. The bench provokes this by asserting the write strobe and the base tick together at a divide ratio of 1. It then expects `cur_count` to show the newly written value and, one tick later, exactly one less. A second directed case advances the prescaler part way at divide-by-2 before rewriting the count, and requires that the next single base tick leaves the count unchanged.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

  localparam int CNT_W   = 32;
  localparam int VEC_W   = 8;
  localparam int SHIFT_W = 3;
  localparam int CFG_W   = 4;
  localparam int CTRL_W  = 32;

  // control word field positions
  localparam int CTRL_PERIODIC_BIT = 17;
  localparam int CTRL_MASK_BIT     = 16;

  typedef struct packed {
    logic             periodic;
    logic             masked;
    logic [VEC_W-1:0] vector;
  } tmr_ctrl_t;

  // scattered 3-bit divide code, shift = code + 1 wrapping at 8
  function automatic logic [SHIFT_W-1:0] cfg_to_shift(input logic [CFG_W-1:0] cfg);
    logic [SHIFT_W-1:0] code;
    code = {cfg[3], cfg[1:0]};
    return code + SHIFT_W'(1);
  endfunction

endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler #(
  parameter int SHIFT_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_i,
  input  logic               restart_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic               div_tick_o
);

  localparam int PRE_W = (1 << SHIFT_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_mask;
  logic             at_end;

  // bit b of the phase counter takes part when the shift exceeds b
  for (genvar b = 0; b < PRE_W; b++) begin : g_mask
    assign pre_mask[b] = (shift_i > SHIFT_W'(b));
  end

  assign at_end     = &(pre_q | ~pre_mask);
  assign div_tick_o = tick_i && !restart_i && at_end;

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      pre_q <= '0;
    end else if (tick_i) begin
      pre_q <= at_end ? '0 : pre_q + PRE_W'(1);
    end
  end

endmodule

// File: rtl/tmr_cfg_regs.sv
`timescale 1ns/1ps
module tmr_cfg_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W_P = CNT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               init_we,
  input  logic [CNT_W_P-1:0] init_data,
  input  logic               div_we,
  input  logic [CFG_W-1:0]   div_cfg,
  input  logic               ctrl_we,
  input  logic [CTRL_W-1:0]  ctrl_data,
  output logic [CNT_W_P-1:0] init_q,
  output logic [SHIFT_W-1:0] shift_q,
  output tmr_ctrl_t          ctrl_q,
  output logic               restart
);

  logic cfg_unused;
  logic ctrl_unused;

  assign cfg_unused  = div_cfg[2];
  assign ctrl_unused = ^{ctrl_data[CTRL_W-1:CTRL_PERIODIC_BIT+1],
                         ctrl_data[CTRL_MASK_BIT-1:VEC_W]};

  assign restart = init_we || div_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      init_q  <= '0;
      shift_q <= cfg_to_shift('0);
      ctrl_q  <= '{periodic: 1'b0, masked: 1'b1, vector: '0};
    end else begin
      if (init_we) init_q  <= init_data;
      if (div_we)  shift_q <= cfg_to_shift(div_cfg);
      if (ctrl_we) begin
        ctrl_q.periodic <= ctrl_data[CTRL_PERIODIC_BIT];
        ctrl_q.masked   <= ctrl_data[CTRL_MASK_BIT];
        ctrl_q.vector   <= ctrl_data[VEC_W-1:0];
      end
    end
  end

endmodule

// File: rtl/tmr_countdown.sv
`timescale 1ns/1ps
module tmr_countdown #(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_val_i,
  input  logic             div_tick_i,
  input  logic             periodic_i,
  input  logic             masked_i,
  input  logic [VEC_W-1:0] vector_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o,
  output logic [VEC_W-1:0] irq_vec_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             irq_q;
  logic [VEC_W-1:0] vec_q;
  logic             at_zero;
  logic             expire;

  assign at_zero = (cnt_q == '0);
  // one-shot expires once from zero; periodic expires at every wrap
  assign expire  = div_tick_i && at_zero && (periodic_i || armed_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
      vec_q   <= '0;
    end else begin
      irq_q <= 1'b0;
      if (load_i) begin
        cnt_q   <= load_val_i;
        armed_q <= |load_val_i;
      end else if (div_tick_i) begin
        if (!at_zero) begin
          cnt_q <= cnt_q - CNT_W'(1);
        end else if (periodic_i) begin
          cnt_q   <= reload_val_i;
          armed_q <= 1'b0;
        end else begin
          armed_q <= 1'b0;
        end
        if (expire) begin
          irq_q <= !masked_i;
          vec_q <= vector_i;
        end
      end
    end
  end

  assign count_o   = cnt_q;
  assign irq_o     = irq_q;
  assign irq_vec_o = vec_q;

endmodule

// File: rtl/tick_countdown_timer.sv
`timescale 1ns/1ps
module tick_countdown_timer
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              init_we,
  input  logic [CNT_W-1:0]  init_data,
  input  logic              div_we,
  input  logic [CFG_W-1:0]  div_cfg,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_data,
  output logic [CNT_W-1:0]  cur_count,
  output logic              irq_valid,
  output logic [VEC_W-1:0]  irq_vector,
  output logic              irq_level
);

  logic [CNT_W-1:0]   init_q;
  logic [SHIFT_W-1:0] shift_q;
  tmr_ctrl_t          ctrl_q;
  logic               restart;
  logic               div_tick;
  logic               ctrl_mask;
  logic               ctrl_periodic;
  logic [VEC_W-1:0]   ctrl_vec;

  tmr_cfg_regs #(.CNT_W_P(CNT_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .init_we   (init_we),
    .init_data (init_data),
    .div_we    (div_we),
    .div_cfg   (div_cfg),
    .ctrl_we   (ctrl_we),
    .ctrl_data (ctrl_data),
    .init_q    (init_q),
    .shift_q   (shift_q),
    .ctrl_q    (ctrl_q),
    .restart   (restart)
  );

  tmr_prescaler #(.SHIFT_W(SHIFT_W)) u_pre (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick_i),
    .restart_i  (restart),
    .shift_i    (shift_q),
    .div_tick_o (div_tick)
  );

  assign ctrl_mask     = ctrl_q.masked;
  assign ctrl_periodic = ctrl_q.periodic;
  assign ctrl_vec      = ctrl_q.vector;

  tmr_countdown #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_cnt (
    .clk          (clk),
    .rst          (rst),
    .load_i       (init_we),
    .load_val_i   (init_data),
    .reload_val_i (init_q),
    .div_tick_i   (div_tick),
    .periodic_i   (ctrl_periodic),
    .masked_i     (ctrl_mask),
    .vector_i     (ctrl_vec),
    .count_o      (cur_count),
    .irq_o        (irq_valid),
    .irq_vec_o    (irq_vector)
  );

  assign irq_level = 1'b0;

endmodule

// File: rtl/tick_countdown_timer_chk.sv
`timescale 1ns/1ps
module tick_countdown_timer_chk
  import tmr_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              init_we,
  input logic [CNT_W-1:0]  init_data,
  input logic [CNT_W-1:0]  cur_count,
  input logic              irq_valid,
  input logic [VEC_W-1:0]  irq_vector,
  input logic              ctrl_mask,
  input logic              ctrl_periodic,
  input logic [VEC_W-1:0]  ctrl_vec
);

  a_r3_load_wins: assert property (@(posedge clk) disable iff (rst)
    $past(init_we) |-> cur_count == $past(init_data));

  a_r4_step_by_one: assert property (@(posedge clk) disable iff (rst)
    (!$past(init_we) && cur_count < $past(cur_count))
      |-> cur_count == $past(cur_count) - CNT_W'(1));

  a_r6_rise_only_on_wrap: assert property (@(posedge clk) disable iff (rst)
    (!$past(init_we) && cur_count > $past(cur_count))
      |-> ($past(cur_count) == '0 && $past(ctrl_periodic)));

  a_r7_no_masked_request: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> !$past(ctrl_mask));

  a_r9_request_from_zero: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> ($past(cur_count) == '0 && !$past(init_we)));

  a_r9_vector_carried: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> irq_vector == $past(ctrl_vec));

endmodule

bind tick_countdown_timer tick_countdown_timer_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .init_we       (init_we),
  .init_data     (init_data),
  .cur_count     (cur_count),
  .irq_valid     (irq_valid),
  .irq_vector    (irq_vector),
  .ctrl_mask     (ctrl_mask),
  .ctrl_periodic (ctrl_periodic),
  .ctrl_vec      (ctrl_vec)
);

// File: tb/tick_countdown_timer_tb.sv
`timescale 1ns/1ps
module tick_countdown_timer_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 1'b0;
  logic        init_we = 1'b0;
  logic [31:0] init_data = '0;
  logic        div_we = 1'b0;
  logic [3:0]  div_cfg = '0;
  logic        ctrl_we = 1'b0;
  logic [31:0] ctrl_data = '0;
  logic [31:0] cur_count;
  logic        irq_valid;
  logic [7:0]  irq_vector;
  logic        irq_level;

  int n_tests = 0;
  int n_fail  = 0;
  int pulses  = 0;
  logic [7:0] exp_vec = '0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  tick_countdown_timer u_dut (
    .clk(clk), .rst(rst), .tick_i(tick_i),
    .init_we(init_we), .init_data(init_data),
    .div_we(div_we), .div_cfg(div_cfg),
    .ctrl_we(ctrl_we), .ctrl_data(ctrl_data),
    .cur_count(cur_count), .irq_valid(irq_valid),
    .irq_vector(irq_vector), .irq_level(irq_level)
  );

  // rows: {nticks[15:0], init[15:0], vec[7:0], 2'b0, mask, periodic, cfg[3:0]}
  localparam int NROWS = 14;
  localparam logic [47:0] ROWS [NROWS] = '{
    {16'd3,   16'd5, 8'h21, 2'b0, 1'b0, 1'b0, 4'hB},
    {16'd6,   16'd5, 8'h22, 2'b0, 1'b0, 1'b0, 4'hB},
    {16'd20,  16'd5, 8'h23, 2'b0, 1'b0, 1'b0, 4'hB},
    {16'd9,   16'd4, 8'h24, 2'b0, 1'b0, 1'b0, 4'h0},
    {16'd10,  16'd4, 8'h25, 2'b0, 1'b0, 1'b0, 4'h0},
    {16'd10,  16'd4, 8'h26, 2'b0, 1'b0, 1'b0, 4'h4},
    {16'd40,  16'd3, 8'h27, 2'b0, 1'b0, 1'b1, 4'h1},
    {16'd100, 16'd1, 8'h28, 2'b0, 1'b0, 1'b1, 4'h3},
    {16'd200, 16'd2, 8'h29, 2'b0, 1'b0, 1'b1, 4'h8},
    {16'd7,   16'd0, 8'h2A, 2'b0, 1'b0, 1'b1, 4'hB},
    {16'd10,  16'd0, 8'h2B, 2'b0, 1'b0, 1'b0, 4'hB},
    {16'd10,  16'd2, 8'h2C, 2'b0, 1'b1, 1'b1, 4'hB},
    {16'd130, 16'd1, 8'h2D, 2'b0, 1'b0, 1'b0, 4'h9},
    {16'd55,  16'd4, 8'h2E, 2'b0, 1'b0, 1'b1, 4'h2}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // sample last edge's results, then drive this cycle's inputs
  task automatic step(input bit tk, input bit iw, input logic [31:0] id,
                      input bit dw, input logic [3:0] dc,
                      input bit cw, input logic [31:0] cd);
    @(negedge clk);
    if (irq_valid) begin
      pulses++;
      chk(irq_vector == exp_vec, "R9 vector", irq_vector, exp_vec);
      chk(irq_level == 1'b0, "R9 edge mode", irq_level, 0);
    end
    tick_i = tk; init_we = iw; init_data = id;
    div_we = dw; div_cfg = dc; ctrl_we = cw; ctrl_data = cd;
  endtask

  task automatic idle();
    step(0, 0, '0, 0, '0, 0, '0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1, 0, '0, 0, '0, 0, '0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    idle(); idle();
    @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic logic [31:0] mk_ctrl(input bit per, input bit msk, input logic [7:0] v);
    logic [31:0] c;
    c = '0;
    c[17] = per;
    c[16] = msk;
    c[7:0] = v;
    return c;
  endfunction

  function automatic int shift_of(input logic [3:0] cfg);
    int v;
    v = {cfg[3], cfg[1:0]};
    return (v + 1) % 8;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // reset state
    do_reset();
    @(negedge clk);
    chk(cur_count == 0, "R3 reset count", cur_count, 0);
    chk(irq_valid == 0, "R9 reset request", irq_valid, 0);

    // table walk: R1 R4 R5 R6 R7
    for (int r = 0; r < NROWS; r++) begin
      logic [3:0] cfg;
      bit per, msk;
      int init, n, d, sh, ecnt, eirq;
      cfg  = ROWS[r][3:0];
      per  = ROWS[r][4];
      msk  = ROWS[r][5];
      init = int'(ROWS[r][31:16]);
      n    = int'(ROWS[r][47:32]);
      sh   = shift_of(cfg);
      d    = n >> sh;
      if (per) begin
        ecnt = init - (d % (init + 1));
        eirq = d / (init + 1);
      end else begin
        ecnt = (d >= init) ? 0 : init - d;
        eirq = (init != 0 && d >= init + 1) ? 1 : 0;
      end
      if (msk) eirq = 0;
      do_reset();
      exp_vec = ROWS[r][15:8];
      step(0, 0, '0, 1, cfg, 0, '0);
      step(0, 0, '0, 0, '0, 1, mk_ctrl(per, msk, ROWS[r][15:8]));
      step(0, 1, 32'(init), 0, '0, 0, '0);
      pulses = 0;
      ticks(n);
      idle();
      chk(cur_count == 32'(ecnt), per ? "R6 R1 periodic count" : "R4 R1 one-shot count",
          cur_count, ecnt);
      chk(pulses == eirq, msk ? "R7 masked requests" : (per ? "R6 periodic requests" : "R5 one-shot requests"),
          pulses, eirq);
    end

    // R3: load collides with a divided tick at divide-by-1
    do_reset();
    exp_vec = 8'h51;
    step(0, 0, '0, 1, 4'hB, 0, '0);
    step(0, 0, '0, 0, '0, 1, mk_ctrl(0, 0, 8'h51));
    step(0, 1, 32'd10, 0, '0, 0, '0);
    ticks(3);
    step(1, 1, 32'd20, 0, '0, 0, '0);
    idle();
    chk(cur_count == 20, "R3 load wins over tick", cur_count, 20);
    ticks(1);
    idle();
    chk(cur_count == 19, "R3 next tick after load", cur_count, 19);

    // R2: prescaler phase cleared by a load at divide-by-2
    do_reset();
    step(0, 0, '0, 1, 4'h0, 0, '0);
    step(0, 1, 32'd8, 0, '0, 0, '0);
    ticks(1);
    step(0, 1, 32'd8, 0, '0, 0, '0);
    ticks(1);
    idle();
    chk(cur_count == 8, "R2 restart after load", cur_count, 8);
    ticks(1);
    idle();
    chk(cur_count == 7, "R2 first divided tick", cur_count, 7);

    // R2: divide-setting write also clears the phase
    step(0, 0, '0, 1, 4'h0, 0, '0);
    ticks(1);
    idle();
    chk(cur_count == 7, "R2 restart after divide write", cur_count, 7);

    // R8: unmask before expiry
    do_reset();
    exp_vec = 8'h44;
    step(0, 0, '0, 1, 4'hB, 0, '0);
    step(0, 0, '0, 0, '0, 1, mk_ctrl(0, 1, 8'h33));
    step(0, 1, 32'd3, 0, '0, 0, '0);
    pulses = 0;
    ticks(2);
    step(0, 0, '0, 0, '0, 1, mk_ctrl(0, 0, 8'h44));
    ticks(3);
    idle();
    chk(pulses == 1, "R8 unmasked expiry", pulses, 1);
    chk(cur_count == 0, "R8 count after unmask", cur_count, 0);

    // R8: periodic switched to one-shot before first reload
    do_reset();
    exp_vec = 8'h66;
    step(0, 0, '0, 1, 4'hB, 0, '0);
    step(0, 0, '0, 0, '0, 1, mk_ctrl(1, 0, 8'h66));
    step(0, 1, 32'd2, 0, '0, 0, '0);
    pulses = 0;
    ticks(2);
    step(0, 0, '0, 0, '0, 1, mk_ctrl(0, 0, 8'h66));
    ticks(5);
    idle();
    chk(pulses == 1, "R8 mode switch request", pulses, 1);
    chk(cur_count == 0, "R8 mode switch count", cur_count, 0);

    // R9: pulse lasts one cycle, timing after the expiring tick
    do_reset();
    exp_vec = 8'h77;
    step(0, 0, '0, 1, 4'hB, 0, '0);
    step(0, 0, '0, 0, '0, 1, mk_ctrl(0, 0, 8'h77));
    step(0, 1, 32'd1, 0, '0, 0, '0);
    ticks(2);
    @(negedge clk);
    chk(irq_valid == 1, "R9 pulse after expiry", irq_valid, 1);
    chk(irq_vector == 8'h77, "R9 pulse vector", irq_vector, 8'h77);
    @(negedge clk);
    chk(irq_valid == 0, "R9 pulse one cycle", irq_valid, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule